// File: doc/BRIEF.md
# Serial Single-Error Cyclic Decoder

This block decodes a bit-serial stream of cyclic-code words and repairs at most one flipped bit per word. It is built for the (7,4) code whose generator polynomial is 1 + X + X^3. The code length, the number of parity bits and the generator are parameters, so any cyclic code whose generator divides X^N + 1 fits the same structure. A word arrives one bit per valid cycle, highest-order coefficient first. While it arrives, it is divided by the generator in a P-stage syndrome register and is also kept in an N-bit holding register.

Once the last bit is in, the block drains the holding register for N cycles. Each cycle it compares the syndrome against the one pattern that marks an error in the bit about to leave. A match inverts that bit and feeds a one back into the left end of the syndrome register, which removes the error's effect before the next cyclic shift. The last output bit carries an end marker and a flag that reports whether any syndrome was left over.

The two phases do not overlap. Input bits offered while a word is draining are dropped.

Top module: `cyclic_serial_decoder`

## Requirements
- R1: During reset and after it, `outValid`, `outBit`, `blockEnd` and `uncorrectable` are all 0.
- R2: A word is collected from exactly N cycles with `inValid` high, taken in the order r[N-1] first down to r[0]. Cycles with `inValid` low neither add a bit nor advance the count. `outValid` stays 0 while a word is being collected.
- R3: On the clock edge after the Nth accepted bit, `outValid` goes high. It then stays high for exactly N consecutive cycles, and the bits come out highest-order coefficient first.
- R4: A valid codeword is emitted unchanged, and `uncorrectable` is 0 at its end.
- R5: A codeword with exactly one inverted bit, at any of the N positions, is emitted as the original codeword.
- R6: The detector fires only while draining, and only when the syndrome register holds X^(N-1) mod g(X), with bit i of the register holding the coefficient of X^i. With the default generator this is bits {2,1,0} = 101.
- R7: When the detector fires, the outgoing bit is inverted and a 1 enters the left end of the syndrome register on that shift. After a correction the syndrome register is zero.
- R8: `blockEnd` is 1 on exactly the cycle that carries the Nth output bit. `uncorrectable` can be 1 only on that cycle, and it is 1 when the syndrome left after N drain shifts is nonzero. With the (15,7) setting this holds for every two-bit error, and such a word comes out uncorrected.
- R9: Input bits and `inValid` presented while a word is draining have no effect on that word or on the next one.
- R10: Words may follow back to back. The syndrome register is cleared at the end of each word, so each word is decoded independently.
- R11: The parameters N, P and GEN select the code, and the detector pattern is derived from them. A (15,7) code with generator 1 + X^4 + X^6 + X^7 + X^8 decodes single errors in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks `inBit` as a received bit |
| inBit | input | 1 | Received serial bit, highest order first |
| outValid | output | 1 | Marks `outBit` as a decoded bit |
| outBit | output | 1 | Corrected serial bit, highest order first |
| blockEnd | output | 1 | High with the last bit of a word |
| uncorrectable | output | 1 | Nonzero residual syndrome, valid with `blockEnd` |

## Verification
The bench builds two instances. One uses the default (7,4) code with generator 1011. The other uses N=15, P=8 and generator 0x1D1, a double-error-distance code.

The (7,4) code is perfect: every syndrome is the syndrome of some single error, so the residual flag can never rise there. The (15,7) instance is therefore the one that reaches the uncorrectable path, and the bench drives it with two-bit errors that leave a nonzero residual. Both instances receive every single-bit error on a set of codewords. They also receive gaps in `inValid` and random junk during draining.

// File: rtl/cyc_dec_pkg.sv
package cyc_dec_pkg;

  // Phase of the decoder: collecting a word, or emitting it
  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;    // accept one received bit
    logic drainStep;  // emit one bit, test-and-shift syndrome
    logic lastStep;   // final drain step of the word
  } dec_strobe_t;

endpackage

// File: rtl/cyc_dec_ctrl.sv
module cyc_dec_ctrl
  import cyc_dec_pkg::*;
#(
  parameter int N = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output dec_strobe_t strobe
);

  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          atLast;

  assign atLast = (cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_FILL;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_FILL: begin
          if (inValid) begin
            if (atLast) begin
              phase <= PH_DRAIN;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_DRAIN: begin
          if (atLast) begin
            phase <= PH_FILL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_FILL;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe.shiftIn   = (phase == PH_FILL) && inValid;
    strobe.drainStep = (phase == PH_DRAIN);
    strobe.lastStep  = (phase == PH_DRAIN) && atLast;
  end

  // R2: the bit counter never leaves the word length
  p_count_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST_IDX);

  // R3: draining is entered only right after an accepted bit
  p_drain_after_bit_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phase == PH_DRAIN) |-> $past(inValid));

endmodule

// File: rtl/cyc_dec_detect.sv
module cyc_dec_detect #(
  parameter int           P   = 3,
  parameter logic [P-1:0] HIT = 3'b101
) (
  input  logic [P-1:0] syn,
  input  logic         enable,
  output logic         hit
);

  // Single-position matcher: error in the bit now leaving the buffer
  assign hit = enable && (syn == HIT);

endmodule

// File: rtl/cyc_dec_dp.sv
module cyc_dec_dp
  import cyc_dec_pkg::*;
#(
  parameter int         N   = 7,
  parameter int         P   = 3,
  parameter logic [P:0] GEN = 4'b1011
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inBit,
  input  dec_strobe_t strobe,
  output logic        outValid,
  output logic        outBit,
  output logic        blockEnd,
  output logic        uncorrectable
);

  localparam logic [P-1:0] TAP = GEN[P-1:0];

  // X^e mod g(X), bit i = coefficient of X^i
  function automatic logic [P-1:0] powMod(input int e);
    logic [P-1:0] r;
    logic         fb;
    r = P'(1);
    for (int i = 0; i < e; i++) begin
      fb = r[P-1];
      r  = {r[P-2:0], 1'b0};
      if (fb) r = r ^ TAP;
    end
    return r;
  endfunction

  localparam logic [P-1:0] HIT = powMod(N - 1);

  logic [P-1:0] syn;
  logic [P-1:0] synNext;
  logic [N-1:0] bufReg;
  logic         det;
  logic         feed;

  cyc_dec_detect #(
    .P   (P),
    .HIT (HIT)
  ) u_detect (
    .syn    (syn),
    .enable (strobe.drainStep),
    .hit    (det)
  );

  // One divider serves both phases: the received bit while filling,
  // the detector output while draining
  assign feed    = strobe.shiftIn ? inBit : det;
  assign synNext = {syn[P-2:0], feed} ^ (syn[P-1] ? TAP : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syn           <= '0;
      bufReg        <= '0;
      outValid      <= 1'b0;
      outBit        <= 1'b0;
      blockEnd      <= 1'b0;
      uncorrectable <= 1'b0;
    end else begin
      outValid      <= strobe.drainStep;
      outBit        <= strobe.drainStep ? (bufReg[N-1] ^ det) : 1'b0;
      blockEnd      <= strobe.lastStep;
      uncorrectable <= strobe.lastStep && (|synNext);
      if (strobe.shiftIn) begin
        syn    <= synNext;
        bufReg <= {bufReg[N-2:0], inBit};
      end else if (strobe.drainStep) begin
        syn    <= strobe.lastStep ? '0 : synNext;
        bufReg <= {bufReg[N-2:0], 1'b0};
      end
    end
  end

  // R7: a correction cancels the whole syndrome
  p_fix_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    det |=> (syn == '0));

  // R3: output bits of one word come without gaps
  p_valid_burst_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !blockEnd) |=> outValid);

  // R8: end marker rides on a valid bit
  p_end_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    blockEnd |-> outValid);

  // R8: residual flag only with the end marker
  p_flag_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    uncorrectable |-> blockEnd);

endmodule

// File: rtl/cyclic_serial_decoder.sv
module cyclic_serial_decoder
  import cyc_dec_pkg::*;
#(
  parameter int         N   = 7,
  parameter int         P   = 3,
  parameter logic [P:0] GEN = 4'b1011
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inBit,
  output logic outValid,
  output logic outBit,
  output logic blockEnd,
  output logic uncorrectable
);

  dec_strobe_t strobe;

  cyc_dec_ctrl #(
    .N (N)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe)
  );

  cyc_dec_dp #(
    .N   (N),
    .P   (P),
    .GEN (GEN)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .inBit         (inBit),
    .strobe        (strobe),
    .outValid      (outValid),
    .outBit        (outBit),
    .blockEnd      (blockEnd),
    .uncorrectable (uncorrectable)
  );

endmodule

// File: tb/cyclic_serial_decoder_tb.sv
module cyclic_serial_decoder_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic vA = 1'b0, bA = 1'b0, ovA, obA, beA, ucA;
  logic vB = 1'b0, bB = 1'b0, ovB, obB, beB, ucB;

  int errors = 0;
  int checks = 0;

  cyclic_serial_decoder u_dut (
    .clk (clk), .rstN (rstN), .inValid (vA), .inBit (bA),
    .outValid (ovA), .outBit (obA), .blockEnd (beA), .uncorrectable (ucA)
  );

  cyclic_serial_decoder #(
    .N (15), .P (8), .GEN (9'h1D1)
  ) u_dut_wide (
    .clk (clk), .rstN (rstN), .inValid (vB), .inBit (bB),
    .outValid (ovB), .outBit (obB), .blockEnd (beB), .uncorrectable (ucB)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Remainder of v(X) divided by g(X) of degree p, v of length n
  function automatic int pmod(input int v, input int n, input int p, input int g);
    int r = v;
    for (int i = n - 1; i >= p; i--)
      if (r[i]) r = r ^ (g << (i - p));
    return r & ((1 << p) - 1);
  endfunction

  function automatic int pmul(input int m, input int g);
    int r = 0;
    for (int i = 0; i < 16; i++)
      if (m[i]) r = r ^ (g << i);
    return r;
  endfunction

  task automatic drive(input int sel, input logic v, input logic b);
    if (sel == 0) begin vA = v; bA = b; end
    else begin vB = v; bB = b; end
  endtask

  // Feed one word, then follow its N output cycles against the model
  task automatic runBlock(input int sel, input int rx, input bit gaps, input string req);
    int n = (sel != 0) ? 15 : 7;
    int p = (sel != 0) ? 8 : 3;
    int g = (sel != 0) ? 'h1D1 : 'hB;
    int s, expw, unc, ov, ob, be, uc;
    bit found;
    s = pmod(rx, n, p, g);
    expw = rx;
    found = 0;
    if (s != 0)
      for (int j = 0; j < n; j++)
        if (pmod(1 << j, n, p, g) == s) begin
          expw = expw ^ (1 << j);
          found = 1;
        end
    unc = (s != 0 && !found) ? 1 : 0;
    for (int j = n - 1; j >= 0; j--) begin
      if (gaps && (j % 2 == 0)) begin
        @(negedge clk);
        drive(sel, 1'b0, 1'($urandom & 1));
        ov = (sel != 0) ? ovB : ovA;
        check("R2", "outValid idle gap", ov, 0);
      end
      @(negedge clk);
      drive(sel, 1'b1, rx[j]);
      ov = (sel != 0) ? ovB : ovA;
      check("R2", "outValid while filling", ov, 0);
    end
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      ov = (sel != 0) ? ovB : ovA;
      ob = (sel != 0) ? obB : obA;
      be = (sel != 0) ? beB : beA;
      uc = (sel != 0) ? ucB : ucA;
      if (k == 0) begin
        check("R3", "outValid before first drain edge", ov, 0);
      end else begin
        check({req, " R3"}, "outValid", ov, 1);
        check({req, " R7 R9 R10"}, $sformatf("bit X^%0d", n - k), ob, expw[n - k]);
        check("R8", "blockEnd", be, (k == n) ? 1 : 0);
        check({req, " R8"}, "uncorrectable", uc, (k == n) ? unc : 0);
      end
      if (k < n) drive(sel, 1'b1, 1'($urandom & 1));   // R9 junk while draining
      else       drive(sel, 1'b0, 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int cw;
    int msgs[6] = '{0, 1, 'h55, 'h7F, 'h2A, 'h13};
    repeat (3) @(negedge clk);
    check("R1", "outValid in reset", ovA, 0);
    check("R1", "blockEnd in reset", beA, 0);
    check("R1", "uncorrectable in reset", ucA, 0);
    check("R1", "outBit in reset", obA, 0);
    check("R1", "wide outValid in reset", ovB, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "outValid after reset", ovA, 0);
    check("R1", "blockEnd after reset", beA, 0);

    // Default (7,4) code: every message, clean and every single error
    for (int m = 0; m < 16; m++) begin
      cw = pmul(m, 'hB);
      runBlock(0, cw, (m % 3) == 0, "R4");
      for (int j = 0; j < 7; j++)
        runBlock(0, cw ^ (1 << j), ((m + j) % 4) == 0, "R5 R6");
    end

    // (15,7) code: clean, all singles, and doubles left uncorrected
    foreach (msgs[i]) begin
      cw = pmul(msgs[i], 'h1D1);
      runBlock(1, cw, (i % 2) == 1, "R4 R11");
      for (int j = 0; j < 15; j++)
        runBlock(1, cw ^ (1 << j), (j % 5) == 0, "R5 R6 R11");
      for (int j = 0; j < 5; j++)
        runBlock(1, cw ^ (1 << j) ^ (1 << ((j + 3 + i) % 15)), 1'b0, "R8 R11");
    end

    summary();
    $finish;
  end

endmodule